// File: doc/BRIEF.md
# IN Endpoint Transmit Buffer Validator

This block holds one outgoing packet for a single device-to-host endpoint. A local processor fills it through a data port. Each port write stores either two bytes or four bytes, depending on the width-mode input, at the current write position. The block keeps a running byte count and arms the buffer without any commit step. Arming happens when that count reaches the programmed packet-size limit, or reaches a shorter length that was loaded to cut a final short packet. A force input arms a short packet at any time. Once the buffer is armed, a host token pulse streams the packet out one byte per cycle on a byte-wide output. The buffer then empties and is ready for the next fill.

A controller state machine has three states. `TXV_FILL` accepts port writes. `TXV_ARMED` holds a complete packet that waits for a token. `TXV_DRAIN` streams the bytes out. There are four transitions. *arm* goes from FILL to ARMED, on a threshold hit or a force. *launch* goes from ARMED to DRAIN when a token arrives. *finish* goes from DRAIN to FILL after the final byte, or at once for an empty packet. *flush* goes from any state to FILL on bus reset. A small register unit holds the packet-size limit and the length registers, and derives the active threshold. A byte store holds the packet data.

Top module: `txv_in_endpoint`

## Requirements
- R1: In 16-bit mode (`wide_mode`=0) each accepted data-port write adds 2 to `byte_count`. It stores `dp_wdata[7:0]` at byte position `byte_count` and `dp_wdata[15:8]` at the next position. Bits 31:16 are ignored.
- R2: In 32-bit mode (`wide_mode`=1) each accepted write adds 4 to `byte_count` and stores the four bytes little-endian: `dp_wdata[7:0]` goes first.
- R3: With the length register at zero or at least the packet-size limit, the buffer arms (`buf_valid`=1) at the clock edge of the write that brings `byte_count` to or past the limit. A limit of 0 or above `BUF_BYTES` acts as `BUF_BYTES`. After reset the limit is `BUF_BYTES`.
- R4: A write to the packet-size limit (`mps_wr`) also loads the length register with the same value. `blen_wr` may then overwrite the length alone. When both strobes are high, `mps_wr` wins.
- R5: A nonzero length below the limit becomes the threshold. If a write steps past it, the armed packet length is the threshold and not the byte count. The extra bytes are never sent.
- R6: `force_valid` during fill arms the buffer with the current count as the packet length. This count includes a write made in the same cycle. A zero count gives an empty packet that emits no bytes and returns to fill.
- R7: Data-port writes while armed or draining change neither `byte_count` nor the stored bytes. They set `overrun`, which stays set until bus reset or reset.
- R8: An `in_token` pulse while armed starts the drain. From the cycle after the token, one stored byte per cycle appears on `tx_byte` with `tx_valid`=1, in write order, for exactly the packet length. `tx_last` marks the final byte.
- R9: After the final byte, `buf_valid` falls and `byte_count` returns to 0. The next packet is stored from byte position 0.
- R10: `in_token` during fill is ignored: no byte is emitted and the count is kept.
- R11: `bus_reset` clears the length register, `byte_count`, `buf_valid` and `overrun` and returns to fill. The packet-size limit is kept and becomes the threshold.
- R12: After `rst_n` the block is in fill with zero count, zero length register, no overrun, no output byte, and limit `BUF_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous bus reset: flush and clear length |
| wide_mode | input | 1 | 1 = 32-bit data port, 0 = 16-bit |
| dp_wr | input | 1 | Data-port write strobe |
| dp_wdata | input | 32 | Data-port write data |
| mps_wr | input | 1 | Packet-size limit write strobe |
| mps_wdata | input | CW | Packet-size limit value |
| blen_wr | input | 1 | Length register write strobe |
| blen_wdata | input | CW | Length register value |
| force_valid | input | 1 | Arm a short packet now |
| in_token | input | 1 | Host token pulse |
| tx_valid | output | 1 | Output byte present |
| tx_byte | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of packet |
| buf_valid | output | 1 | Packet armed or draining |
| overrun | output | 1 | Sticky: write refused while armed |
| byte_count | output | CW | Bytes written into the current packet |
| mps_value | output | CW | Packet-size limit register |
| blen_value | output | CW | Length register |

## Verification
The bench runs a small 16-byte configuration. In both port widths it sweeps every length from 1 to 16 under a full limit, and every limit from 0 to 16 with the length that the limit write loads. Odd and non-multiple-of-four thresholds tell arming at "reaches" apart from arming at "passes". They also show whether the sent length is cut to the threshold. Checks are made after every single write, so arming one write early or one write late is caught, as are byte-order and lane errors in each mode. Separate sequences cover a forced short packet, a write and a force in the same cycle, an empty forced packet, writes refused while armed, a token during fill, and a bus reset that keeps the limit.

// File: rtl/txv_pkg.sv
package txv_pkg;

    typedef enum logic [1:0] {
        TXV_FILL  = 2'd0,
        TXV_ARMED = 2'd1,
        TXV_DRAIN = 2'd2
    } txv_state_e;

    localparam int TXV_LANES = 4;

endpackage

// File: rtl/txv_regs.sv
module txv_regs #(
    parameter int BUF_BYTES = 64,
    localparam int CW = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rst,
    input  logic          mps_wr,
    input  logic [CW-1:0] mps_wdata,
    input  logic          blen_wr,
    input  logic [CW-1:0] blen_wdata,
    output logic [CW-1:0] mps_q,
    output logic [CW-1:0] blen_q,
    output logic [CW-1:0] thr
);

    logic [CW-1:0] lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mps_q  <= CW'(BUF_BYTES);
            blen_q <= '0;
        end else if (bus_rst) begin
            blen_q <= '0;
        end else if (mps_wr) begin
            mps_q  <= mps_wdata;
            blen_q <= mps_wdata;
        end else if (blen_wr) begin
            blen_q <= blen_wdata;
        end
    end

    always_comb begin
        lim = (mps_q == '0 || mps_q > CW'(BUF_BYTES)) ? CW'(BUF_BYTES) : mps_q;
        thr = (blen_q != '0 && blen_q < lim) ? blen_q : lim;
    end

    p_limit_loads_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mps_wr && !bus_rst) |=> (blen_q == $past(mps_wdata)));

    p_bus_reset_length_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (blen_q == '0));

    p_thr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (thr != '0) && (thr <= CW'(BUF_BYTES)));

endmodule

// File: rtl/txv_store.sv
module txv_store
    import txv_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    localparam int CW = $clog2(BUF_BYTES + 1),
    localparam int AW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wide,
    input  logic [CW-1:0] wr_ptr,
    input  logic [31:0]   wdata,
    input  logic [CW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);

    logic [7:0]  mem [BUF_BYTES];
    logic [CW:0] lane_idx [TXV_LANES];
    logic        lane_en  [TXV_LANES];

    for (genvar k = 0; k < TXV_LANES; k++) begin : g_lane
        assign lane_idx[k] = {1'b0, wr_ptr} + (CW+1)'(k);
        assign lane_en[k]  = we && (wide || (k < 2)) &&
                             (lane_idx[k] < (CW+1)'(BUF_BYTES));
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < TXV_LANES; k++) begin
            if (lane_en[k]) begin
                mem[lane_idx[k][AW-1:0]] <= wdata[8*k +: 8];
            end
        end
    end

    assign rd_byte = mem[rd_idx[AW-1:0]];

endmodule

// File: rtl/txv_ctrl.sv
module txv_ctrl
    import txv_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    localparam int CW = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rst,
    input  logic          wide,
    input  logic          dp_wr,
    input  logic          force_val,
    input  logic          in_token,
    input  logic [CW-1:0] thr,
    output logic          mem_we,
    output logic [CW-1:0] wr_ptr,
    output logic [CW-1:0] rd_idx,
    output logic [CW-1:0] byte_count,
    output logic          buf_valid,
    output logic          overrun,
    output logic          tx_valid,
    output logic          tx_last
);

    txv_state_e    state_q, state_d;
    logic [CW-1:0] count_q, len_q, rd_q;
    logic [CW:0]   sum_w;
    logic [CW-1:0] count_nx, cnt_eff, len_for;
    logic          write_ok, hit, drain_end;

    // Datapath terms for the fill side
    always_comb begin
        sum_w    = {1'b0, count_q} + (wide ? (CW+1)'(4) : (CW+1)'(2));
        count_nx = (sum_w > (CW+1)'(BUF_BYTES)) ? CW'(BUF_BYTES) : sum_w[CW-1:0];
        write_ok = (state_q == TXV_FILL) && dp_wr;
        cnt_eff  = write_ok ? count_nx : count_q;
        hit      = write_ok && (count_nx >= thr);
        len_for  = (cnt_eff > thr) ? thr : cnt_eff;
        drain_end = (len_q == '0) || (rd_q == len_q - CW'(1));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXV_FILL:  if (hit || force_val) state_d = TXV_ARMED;
            TXV_ARMED: if (in_token)         state_d = TXV_DRAIN;
            TXV_DRAIN: if (drain_end)        state_d = TXV_FILL;
            default:                         state_d = TXV_FILL;
        endcase
        if (bus_rst) state_d = TXV_FILL;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXV_FILL;
        else        state_q <= state_d;
    end

    // Counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            len_q   <= '0;
            rd_q    <= '0;
            overrun <= 1'b0;
        end else if (bus_rst) begin
            count_q <= '0;
            len_q   <= '0;
            rd_q    <= '0;
            overrun <= 1'b0;
        end else begin
            if (dp_wr && state_q != TXV_FILL) overrun <= 1'b1;
            unique case (state_q)
                TXV_FILL: begin
                    if (write_ok) count_q <= count_nx;
                    if (state_d == TXV_ARMED) len_q <= len_for;
                end
                TXV_ARMED: begin
                    if (in_token) rd_q <= '0;
                end
                TXV_DRAIN: begin
                    rd_q <= rd_q + CW'(1);
                    if (drain_end) count_q <= '0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_we     = write_ok;
        wr_ptr     = count_q;
        rd_idx     = rd_q;
        byte_count = count_q;
        buf_valid  = (state_q != TXV_FILL);
        tx_valid   = (state_q == TXV_DRAIN) && (len_q != '0);
        tx_last    = tx_valid && (rd_q == len_q - CW'(1));
    end

    p_count_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXV_FILL && dp_wr && !bus_rst && count_q < CW'(BUF_BYTES))
        |=> (count_q > $past(count_q)));

    p_refused_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXV_ARMED && dp_wr && !bus_rst) |=> ($stable(count_q) && overrun));

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !bus_rst) |=> overrun);

    p_len_within_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXV_ARMED) |-> (len_q <= count_q));

    p_drain_needs_token_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(in_token));

    p_finish_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXV_DRAIN && drain_end && !bus_rst) |=> (count_q == '0 && !buf_valid));

    p_token_in_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TXV_FILL && in_token) |=> !tx_valid);

endmodule

// File: rtl/txv_in_endpoint.sv
module txv_in_endpoint #(
    parameter int BUF_BYTES = 64,
    localparam int CW = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_reset,
    input  logic          wide_mode,
    input  logic          dp_wr,
    input  logic [31:0]   dp_wdata,
    input  logic          mps_wr,
    input  logic [CW-1:0] mps_wdata,
    input  logic          blen_wr,
    input  logic [CW-1:0] blen_wdata,
    input  logic          force_valid,
    input  logic          in_token,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    output logic          tx_last,
    output logic          buf_valid,
    output logic          overrun,
    output logic [CW-1:0] byte_count,
    output logic [CW-1:0] mps_value,
    output logic [CW-1:0] blen_value
);

    logic [CW-1:0] thr, wr_ptr, rd_idx;
    logic          mem_we;

    txv_regs #(.BUF_BYTES(BUF_BYTES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst    (bus_reset),
        .mps_wr     (mps_wr),
        .mps_wdata  (mps_wdata),
        .blen_wr    (blen_wr),
        .blen_wdata (blen_wdata),
        .mps_q      (mps_value),
        .blen_q     (blen_value),
        .thr        (thr)
    );

    txv_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst    (bus_reset),
        .wide       (wide_mode),
        .dp_wr      (dp_wr),
        .force_val  (force_valid),
        .in_token   (in_token),
        .thr        (thr),
        .mem_we     (mem_we),
        .wr_ptr     (wr_ptr),
        .rd_idx     (rd_idx),
        .byte_count (byte_count),
        .buf_valid  (buf_valid),
        .overrun    (overrun),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last)
    );

    txv_store #(.BUF_BYTES(BUF_BYTES)) u_store (
        .clk     (clk),
        .we      (mem_we),
        .wide    (wide_mode),
        .wr_ptr  (wr_ptr),
        .wdata   (dp_wdata),
        .rd_idx  (rd_idx),
        .rd_byte (tx_byte)
    );

endmodule

// File: tb/tb_txv_in_endpoint.sv
`timescale 1ns/1ps
module tb_txv_in_endpoint;

    localparam int BUF = 16;
    localparam int CW  = $clog2(BUF + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_reset = 1'b0, wide_mode = 1'b0, dp_wr = 1'b0;
    logic [31:0]   dp_wdata = '0;
    logic          mps_wr = 1'b0, blen_wr = 1'b0, force_valid = 1'b0, in_token = 1'b0;
    logic [CW-1:0] mps_wdata = '0, blen_wdata = '0;
    logic          tx_valid, tx_last, buf_valid, overrun;
    logic [7:0]    tx_byte;
    logic [CW-1:0] byte_count, mps_value, blen_value;

    int total = 0, fails = 0, pkt_no = 0;
    bit done = 1'b0;
    logic [7:0] exp_mem [BUF];

    always #5 clk = ~clk;

    txv_in_endpoint #(.BUF_BYTES(BUF)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic logic [7:0] pat(input int n, input int p);
        return 8'((p * 29) + (n * 11) + 3);
    endfunction

    // One data-port write at byte position p; the bench model keeps the bytes
    task automatic put_word(input bit wd, input int n, input int p, input bit store);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) begin
            w[8*k +: 8] = (wd || k < 2) ? pat(n, p + k) : 8'hA5;
            if (store && (wd || k < 2) && (p + k) < BUF) exp_mem[p + k] = pat(n, p + k);
        end
        dp_wdata = w; dp_wr = 1'b1;
        tick();
        dp_wr = 1'b0;
    endtask

    task automatic drain_check(input int len, input string req);
        int bad = 0;
        in_token = 1'b1; tick(); in_token = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (!tx_valid || tx_byte !== exp_mem[i] || tx_last !== (i == len - 1)) bad++;
            tick();
        end
        chk(bad == 0, req, bad, 0);
        chk(!buf_valid && byte_count == 0 && !tx_valid, "R9 cleared after drain",
            int'(byte_count), 0);
    endtask

    // Fill until armed, checking buf_valid after every write
    task automatic run_pkt(input bit wd, input int thr, input string req);
        int step = wd ? 4 : 2;
        int cnt = 0, early = 0;
        wide_mode = wd;
        pkt_no++;
        while (cnt < thr) begin
            put_word(wd, pkt_no, cnt, 1'b1);
            cnt += step;
            if (buf_valid !== (cnt >= thr)) early++;
        end
        chk(early == 0, req, early, 0);
        chk(int'(byte_count) == cnt, wd ? "R2 count step 4" : "R1 count step 2",
            int'(byte_count), cnt);
        drain_check(thr, "R8 drained bytes");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1; tick();
        // R12 reset state
        chk(byte_count == 0 && !buf_valid && !overrun && !tx_valid, "R12 idle", int'(byte_count), 0);
        chk(blen_value == 0, "R12 length reg", int'(blen_value), 0);
        chk(mps_value == CW'(BUF), "R12 limit", int'(mps_value), BUF);

        // R3 default limit, R4 sweep of limits (0 acts as capacity)
        for (int wd = 0; wd < 2; wd++) begin
            for (int m = 0; m <= BUF; m++) begin
                mps_wdata = CW'(m); mps_wr = 1'b1; tick(); mps_wr = 1'b0;
                chk(blen_value == CW'(m), "R4 limit loads length", int'(blen_value), m);
                run_pkt(wd[0], (m == 0) ? BUF : m, "R3 arm at limit");
            end
        end

        // R5 sweep of shorter lengths under a full limit
        mps_wdata = CW'(BUF); mps_wr = 1'b1; tick(); mps_wr = 1'b0;
        for (int wd = 0; wd < 2; wd++) begin
            for (int b = 1; b <= BUF; b++) begin
                blen_wdata = CW'(b); blen_wr = 1'b1; tick(); blen_wr = 1'b0;
                chk(mps_value == CW'(BUF), "R4 length write keeps limit", int'(mps_value), BUF);
                run_pkt(wd[0], b, "R5 arm at length");
            end
        end

        // R6 forced short packet
        blen_wdata = '0; blen_wr = 1'b1; tick(); blen_wr = 1'b0;
        wide_mode = 1'b0; pkt_no++;
        for (int i = 0; i < 3; i++) put_word(1'b0, pkt_no, 2 * i, 1'b1);
        chk(!buf_valid, "R6 not armed before force", int'(buf_valid), 0);
        force_valid = 1'b1; tick(); force_valid = 1'b0;
        chk(buf_valid && byte_count == 6, "R6 forced arm", int'(byte_count), 6);
        drain_check(6, "R6 forced drain");

        // R6 write and force in the same cycle
        pkt_no++;
        force_valid = 1'b1; put_word(1'b0, pkt_no, 0, 1'b1); force_valid = 1'b0;
        chk(buf_valid && byte_count == 2, "R6 write+force", int'(byte_count), 2);
        drain_check(2, "R6 write+force drain");

        // R6 empty forced packet
        force_valid = 1'b1; tick(); force_valid = 1'b0;
        chk(buf_valid, "R6 empty arm", int'(buf_valid), 1);
        in_token = 1'b1; tick(); in_token = 1'b0;
        chk(!tx_valid, "R6 empty emits nothing", int'(tx_valid), 0);
        tick();
        chk(!buf_valid && byte_count == 0, "R6 empty returns to fill", int'(buf_valid), 0);

        // R7 writes refused while armed
        blen_wdata = CW'(4); blen_wr = 1'b1; tick(); blen_wr = 1'b0;
        wide_mode = 1'b1; pkt_no++;
        put_word(1'b1, pkt_no, 0, 1'b1);
        chk(buf_valid && !overrun, "R7 armed, no overrun yet", int'(overrun), 0);
        put_word(1'b1, pkt_no + 50, 0, 1'b0);
        chk(byte_count == 4 && overrun, "R7 refused write", int'(byte_count), 4);
        drain_check(4, "R7 contents unchanged");
        chk(overrun, "R7 overrun sticky", int'(overrun), 1);

        // R10 token during fill
        wide_mode = 1'b0; pkt_no++;
        put_word(1'b0, pkt_no, 0, 1'b1);
        in_token = 1'b1; tick(); in_token = 1'b0;
        chk(!tx_valid && !buf_valid && byte_count == 2, "R10 token ignored", int'(tx_valid), 0);

        // R11 bus reset
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
        chk(blen_value == 0 && byte_count == 0 && !buf_valid && !overrun,
            "R11 bus reset clears", int'(blen_value), 0);
        chk(mps_value == CW'(BUF), "R11 limit kept", int'(mps_value), BUF);
        run_pkt(1'b1, BUF, "R11 threshold is limit");

        $display("%0d/%0d checks passed", total - fails, total);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule